// File: doc/BRIEF.md
# Delegating interrupt priority selector

This block decides, every cycle, whether the hart should take an interrupt and which one. It ANDs the pending bits with the enable bits. It then passes each surviving bit through one of two gates. The gate depends on the bit's delegation flag and on the privilege level the hart is running at. The lowest-numbered survivor is reported as a cause word with the interrupt marker in its top bit.

The block also owns the machine timer pending bit. It holds a timer compare register and sets the pending bit once the real-time count reaches the compare value. Writing a new compare value clears the bit. The pipeline sets `REG_OUT` to choose between a purely combinational result and one that is registered for timing. Entering the trap, dispatching to a vector and any external interrupt controller all sit outside the block.

Top module: `irq_select`

## Requirements
- R1: A line is a candidate only when both its pending bit and its enable bit are 1. A line with its enable bit at 0 never produces a request.
- R2: A line whose delegation bit is 0 is eligible only when the privilege input is below machine. It is also eligible in machine mode (code 3) when the machine global enable is 1.
- R3: A line whose delegation bit is 1 is eligible only in user mode (code 0), or in supervisor mode (code 1) with the supervisor global enable at 1. It is never eligible in machine mode.
- R4: When several lines are eligible, the line with the lowest bit index is reported.
- R5: While a request is raised, bit XLEN-1 of the cause word is 1, the low bits hold the chosen index and every other bit is 0.
- R6: When no line is eligible, the request flag is 0 and the cause word is all zeros.
- R7: At every clock edge where the real-time count is greater than or equal to the stored compare value, bit 7 (the machine timer line) becomes pending. The bit then stays pending, even if the count falls back, until the compare value is written again.
- R8: A compare write loads the new value and clears the machine timer pending bit at that edge, whatever the count is.
- R9: Bit 7 of the external pending input is ignored. Only the timer logic drives that line.
- R10: During and after reset the compare value is all ones, the timer bit is clear and both outputs are 0.
- R11: With `REG_OUT`=1 the outputs equal the combinational result of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | NIRQ | Pending lines (bit 7 ignored) |
| en_i | input | NIRQ | Per-line enables |
| dlg_i | input | NIRQ | Per-line delegation to supervisor |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| rtc_i | input | TW | Real-time counter value |
| cmp_wr_i | input | 1 | Write strobe for the timer compare value |
| cmp_val_i | input | TW | New timer compare value |
| req_o | output | 1 | Interrupt request |
| cause_o | output | XLEN | Cause word: marker in MSB, index in low bits |

## Verification
The bench targets the privilege gates at their edges. Each delegated or non-delegated line is driven in machine mode and in supervisor mode with the global enable on and off. A design that confused the two gates would fire delegated lines while in machine mode, or would suppress non-delegated lines in supervisor mode. Priority is tested with dense pending vectors. A selector that scanned from the top would report the highest index instead of the lowest.

The timer cases cover several behaviours:
- a count equal to the compare value, which catches a strict comparison;
- a count that drops back below the compare value, which catches a pending bit that was not held;
- a compare write while the count is already past the value, which catches a clear that loses to the set.

The external bit 7 is driven high on its own to show that it cannot raise a request. The registered variant is checked against the previous cycle's expectation, which catches a missing or a doubled register stage.

// File: rtl/irq_select.sv
`timescale 1ns/1ps
module irq_select #(
  parameter int XLEN    = 32,
  parameter int NIRQ    = 16,
  parameter int TW      = 64,
  parameter int MTI     = 7,
  parameter bit REG_OUT = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] en_i,
  input  logic [NIRQ-1:0] dlg_i,
  input  logic [1:0]      priv_i,
  input  logic            m_gie_i,
  input  logic            s_gie_i,
  input  logic [TW-1:0]   rtc_i,
  input  logic            cmp_wr_i,
  input  logic [TW-1:0]   cmp_val_i,
  output logic            req_o,
  output logic [XLEN-1:0] cause_o
);
  localparam int IW = $clog2(NIRQ);
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  logic [TW-1:0]   cmp_q;
  logic            mtip_q;
  logic [NIRQ-1:0] pend_eff, cand, elig;
  logic            m_ok, s_ok, any_c;
  logic [IW-1:0]   idx_c;
  logic [XLEN-1:0] cause_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      mtip_q <= 1'b0;
    end else if (cmp_wr_i) begin
      cmp_q  <= cmp_val_i;
      mtip_q <= 1'b0;
    end else if (rtc_i >= cmp_q) begin
      mtip_q <= 1'b1;
    end
  end

  always_comb begin
    pend_eff      = pend_i;
    pend_eff[MTI] = mtip_q;
  end

  assign cand = pend_eff & en_i;
  assign m_ok = (priv_i != PRV_M) || m_gie_i;
  assign s_ok = (priv_i == PRV_U) || ((priv_i == PRV_S) && s_gie_i);
  assign elig = (cand & ~dlg_i & {NIRQ{m_ok}}) | (cand & dlg_i & {NIRQ{s_ok}});
  assign any_c = |elig;

  always_comb begin
    idx_c = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (elig[i]) idx_c = IW'(i);
  end

  assign cause_c = any_c ? {1'b1, {(XLEN-1-IW){1'b0}}, idx_c} : '0;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          req_o   <= 1'b0;
          cause_o <= '0;
        end else begin
          req_o   <= any_c;
          cause_o <= cause_c;
        end
      end
      logic rst_seen_q;
      always_ff @(posedge clk) rst_seen_q <= rst_n;
      p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen_q |-> (req_o == $past(any_c)) && (cause_o == $past(cause_c)));
    end else begin : g_comb
      assign req_o   = any_c;
      assign cause_o = cause_c;
    end
  endgenerate

  p_cand_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    any_c |-> (pend_eff[idx_c] && en_i[idx_c]));
  p_mgate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_c && !dlg_i[idx_c]) |-> (priv_i != 2'd3 || m_gie_i));
  p_sgate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_c && dlg_i[idx_c]) |-> (priv_i == 2'd0 || (priv_i == 2'd1 && s_gie_i)));
  p_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_c |-> ((elig & ((NIRQ'(1) << idx_c) - NIRQ'(1))) == '0));
  p_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (cause_o[XLEN-1] && (cause_o[XLEN-2:IW] == '0)));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (cause_o == '0));
  p_tset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_wr_i && rtc_i >= cmp_q) |=> mtip_q);
  p_tclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_i |=> (!mtip_q && cmp_q == $past(cmp_val_i)));
endmodule

// File: tb/test_irq_select.sv
`timescale 1ns/1ps
module test_irq_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pend = '0, en = '0, dlg = '0;
  logic [1:0]  priv = 2'd3;
  logic        mg = 1'b0, sg = 1'b0, wr = 1'b0;
  logic [63:0] rtc = '0, cmpv = '0;
  logic        req_c, req_r;
  logic [31:0] cause_c, cause_r;

  logic [63:0] cmp_m = '1;
  logic        mtip_m = 1'b0;
  logic [31:0] prev_e = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_select i_irq_select (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .dlg_i(dlg),
    .priv_i(priv), .m_gie_i(mg), .s_gie_i(sg), .rtc_i(rtc),
    .cmp_wr_i(wr), .cmp_val_i(cmpv), .req_o(req_c), .cause_o(cause_c));

  irq_select #(.REG_OUT(1'b1)) i_irq_select_q (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .dlg_i(dlg),
    .priv_i(priv), .m_gie_i(mg), .s_gie_i(sg), .rtc_i(rtc),
    .cmp_wr_i(wr), .cmp_val_i(cmpv), .req_o(req_r), .cause_o(cause_r));

  function automatic logic [31:0] ref_cause();
    logic [15:0] p;
    logic ok;
    p = pend;
    p[7] = mtip_m;
    p = p & en;
    for (int i = 0; i < 16; i++) begin
      if (!dlg[i]) ok = (priv != 2'd3) || mg;
      else         ok = (priv == 2'd0) || (priv == 2'd1 && sg);
      if (p[i] && ok) return 32'h8000_0000 | 32'(i);
    end
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    logic [31:0] e;
    #2;
    e = ref_cause();
    chk(tag, cause_c, e);
    chk(tag, {31'b0, req_c}, {31'b0, e[31]});
    chk({tag, " R11"}, cause_r, prev_e);
    chk({tag, " R11"}, {31'b0, req_r}, {31'b0, prev_e[31]});
    prev_e = e;
    @(posedge clk);
    if (wr) begin cmp_m = cmpv; mtip_m = 1'b0; end
    else if (rtc >= cmp_m) mtip_m = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic set(input logic [15:0] p, input logic [15:0] e, input logic [15:0] d,
                     input logic [1:0] pr, input logic m, input logic s);
    pend = p; en = e; dlg = d; priv = pr; mg = m; sg = s;
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    #2;
    chk("R10 reset cause", cause_c, 32'h0);
    chk("R10 reset req", {31'b0, req_c}, 32'h0);
    chk("R10 reset q", cause_r, 32'h0);
    rtc = 64'hFFFF_FFFF_FFFF_FFFE;
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R10 compare all ones after reset");
    rtc = 0;

    set(16'h0002, 16'h0000, 16'h0, 2'd0, 1, 1); cyc("R1 disabled line");
    set(16'h0002, 16'h0002, 16'h0, 2'd0, 1, 1); cyc("R1 enabled line");
    set(16'h0008, 16'h0008, 16'h0, 2'd3, 0, 1); cyc("R2 machine mode gie off");
    set(16'h0008, 16'h0008, 16'h0, 2'd3, 1, 0); cyc("R2 machine mode gie on");
    set(16'h0008, 16'h0008, 16'h0, 2'd1, 0, 0); cyc("R2 below machine");
    set(16'h0020, 16'h0020, 16'h0020, 2'd3, 1, 1); cyc("R3 delegated in machine");
    set(16'h0020, 16'h0020, 16'h0020, 2'd1, 1, 0); cyc("R3 supervisor gie off");
    set(16'h0020, 16'h0020, 16'h0020, 2'd1, 0, 1); cyc("R3 supervisor gie on");
    set(16'h0020, 16'h0020, 16'h0020, 2'd0, 0, 0); cyc("R3 user mode");
    set(16'hFF7E, 16'hFFFF, 16'h0, 2'd0, 0, 0); cyc("R4 R5 dense vector");
    set(16'hC000, 16'hFFFF, 16'h4000, 2'd3, 1, 0); cyc("R4 R5 high lines");
    set(16'h0000, 16'hFFFF, 16'h0, 2'd0, 1, 1); cyc("R6 nothing pending");
    set(16'h0080, 16'h0080, 16'h0, 2'd0, 1, 1); cyc("R9 external bit 7 ignored");

    cmpv = 64'd5; wr = 1'b1; rtc = 64'd4; cyc("R8 compare write");
    set(16'h0000, 16'h0080, 16'h0, 2'd3, 1, 0);
    cyc("R7 count below compare");
    rtc = 64'd5; cyc("R7 count equals compare");
    rtc = 64'd0; cyc("R7 pending visible");
    cyc("R7 pending held");
    cmpv = 64'd2; wr = 1'b1; rtc = 64'd9; cyc("R8 write clears");
    cyc("R8 cleared after write");
    cyc("R7 set again");

    for (int k = 0; k < 600; k++) begin
      pend = 16'($urandom); en = 16'($urandom); dlg = 16'($urandom);
      case ($urandom % 3) 0: priv = 2'd0; 1: priv = 2'd1; default: priv = 2'd3; endcase
      mg = 1'($urandom); sg = 1'($urandom);
      rtc = 64'($urandom % 16);
      if (($urandom % 8) == 0) begin wr = 1'b1; cmpv = 64'($urandom % 16); end
      if (($urandom % 4) == 0) pend = pend & (16'hFFFF << ($urandom % 16));
      cyc("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule